// File: doc/BRIEF.md
# Multi-Mode NCO Modulation Controller

This block is the control core of a numerically controlled oscillator. A 48-bit phase accumulator advances by an active frequency word on every clock. A 3-bit mode setting decides where that word comes from. It can be a fixed tone, a pin-selected pair of words for frequency shift keying, a word that ramps linearly toward a pin-selected target, or a free-running linear chirp. A fifth mode holds the frequency fixed and switches the output phase offset between two values for binary phase shift keying.

Software writes the settings through a simple write port into a shadow bank. A separate update strobe copies the whole bank into the active settings at once, so every word changes on the same edge. A single keying pin acts as the frequency or phase select, or as a sweep hold, depending on the mode. The block outputs a 14-bit phase word for a downstream phase-to-amplitude stage, together with the active frequency word.

Top module: `nco_mod_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, `phase_word` and `freq_word` are 0 and the active mode is single tone (code 0).
- R2: On each clock edge the accumulator adds the current `freq_word` modulo 2^48. `phase_word` equals accumulator bits [47:34] plus the selected 14-bit phase offset, modulo 2^14.
- R3: Writes go to a shadow bank and change nothing at the outputs until a clock edge with `upd_strobe` high, which copies every shadow field at once. Address map: 0 tuning word A, 1 tuning word B, 2 phase offset A (data bits [13:0]), 3 phase offset B (bits [13:0]), 4 step word (48-bit, two's complement), 5 interval count (bits [15:0]), 6 mode (bits [2:0]). A write on the same edge as the strobe lands only in the shadow bank.
- R4: Mode 0 (single tone): `freq_word` is tuning word A and the offset is phase offset A. The keying pin has no effect.
- R5: Mode 1 (FSK): `freq_word` is tuning word A when the registered pin is low and tuning word B when it is high. The pin is registered once, so `freq_word` follows the pin level sampled at the previous edge. The accumulator is never cleared by a switch.
- R6: Mode 2 (ramped FSK): after a strobe, the ramp starts at tuning word A and its interval counter is loaded with the interval count N. At every (N+1)th edge the ramp moves toward the target (A with the pin low, B with it high) by the step word, taken as unsigned. It lands exactly on the target instead of passing it.
- R7: Mode 3 (chirp): the ramp starts at tuning word A on the strobe. At every (N+1)th edge it adds the signed step word, wrapping modulo 2^48.
- R8: In mode 3, while the registered pin is high, both the ramp value and the interval counter are frozen.
- R9: Mode 4 (BPSK): `freq_word` is tuning word A. The offset is phase offset B when the registered pin is high and phase offset A when it is low.
- R10: Mode codes 5 to 7 behave exactly as single tone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Shadow register write enable |
| wr_addr | input | 3 | Shadow register address |
| wr_data | input | 48 | Write data |
| upd_strobe | input | 1 | Copy shadow bank to active settings |
| key_pin | input | 1 | Keying / hold pin |
| phase_word | output | 14 | Phase word to the amplitude stage |
| freq_word | output | 48 | Active frequency word |

## Verification
A behavioural model runs through each mode in turn. In single tone and in the unused codes the pin is toggled, which tells a correct design apart from one where the pin leaks into frequency or phase. In FSK and BPSK mode the pin is toggled at irregular spacing, which separates the frequency path from the offset path and exposes a missing or doubled pin register. The ramped FSK run uses a step that does not divide the distance to the target, in both directions, so an overshoot or an off-by-one interval shows up. The chirp run uses a negative step with hold pulses inside an interval. Writes without a strobe, and a write on the same edge as the strobe, check that the shadow bank is isolated from the active settings.

// File: rtl/nco_mod_pkg.sv
package nco_mod_pkg;

  typedef enum logic [2:0] {
    MODE_TONE  = 3'd0,
    MODE_FSK   = 3'd1,
    MODE_RFSK  = 3'd2,
    MODE_CHIRP = 3'd3,
    MODE_BPSK  = 3'd4
  } mode_e;

  localparam logic [2:0] ADDR_FTW_A  = 3'd0;
  localparam logic [2:0] ADDR_FTW_B  = 3'd1;
  localparam logic [2:0] ADDR_PH_A   = 3'd2;
  localparam logic [2:0] ADDR_PH_B   = 3'd3;
  localparam logic [2:0] ADDR_STEP   = 3'd4;
  localparam logic [2:0] ADDR_IVAL   = 3'd5;
  localparam logic [2:0] ADDR_MODE   = 3'd6;

endpackage

// File: rtl/nco_regbank.sv
module nco_regbank
  import nco_mod_pkg::*;
#(
  parameter int ACC_W  = 48,
  parameter int PH_W   = 14,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [ACC_W-1:0]  wr_data,
  input  logic              upd_strobe,
  output logic [ACC_W-1:0]  act_ftw_a,
  output logic [ACC_W-1:0]  act_ftw_b,
  output logic [PH_W-1:0]   act_ph_a,
  output logic [PH_W-1:0]   act_ph_b,
  output logic [ACC_W-1:0]  act_step,
  output logic [RATE_W-1:0] act_ival,
  output mode_e             act_mode,
  output logic [ACC_W-1:0]  sh_ftw_a_o,
  output logic [RATE_W-1:0] sh_ival_o
);

  logic [ACC_W-1:0]  sh_ftw_a, sh_ftw_b, sh_step;
  logic [PH_W-1:0]   sh_ph_a, sh_ph_b;
  logic [RATE_W-1:0] sh_ival;
  mode_e             sh_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_ftw_a <= '0;
      sh_ftw_b <= '0;
      sh_step  <= '0;
      sh_ph_a  <= '0;
      sh_ph_b  <= '0;
      sh_ival  <= '0;
      sh_mode  <= MODE_TONE;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_FTW_A: sh_ftw_a <= wr_data;
        ADDR_FTW_B: sh_ftw_b <= wr_data;
        ADDR_PH_A:  sh_ph_a  <= wr_data[PH_W-1:0];
        ADDR_PH_B:  sh_ph_b  <= wr_data[PH_W-1:0];
        ADDR_STEP:  sh_step  <= wr_data;
        ADDR_IVAL:  sh_ival  <= wr_data[RATE_W-1:0];
        ADDR_MODE:  sh_mode  <= mode_e'(wr_data[2:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_ftw_a <= '0;
      act_ftw_b <= '0;
      act_step  <= '0;
      act_ph_a  <= '0;
      act_ph_b  <= '0;
      act_ival  <= '0;
      act_mode  <= MODE_TONE;
    end else if (upd_strobe) begin
      act_ftw_a <= sh_ftw_a;
      act_ftw_b <= sh_ftw_b;
      act_step  <= sh_step;
      act_ph_a  <= sh_ph_a;
      act_ph_b  <= sh_ph_b;
      act_ival  <= sh_ival;
      act_mode  <= sh_mode;
    end
  end

  assign sh_ftw_a_o = sh_ftw_a;
  assign sh_ival_o  = sh_ival;

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_strobe |=> ($stable(act_ftw_a) && $stable(act_mode) && $stable(act_step)))
    else $error("active settings moved without strobe"); // R3

endmodule

// File: rtl/nco_freq_ctrl.sv
module nco_freq_ctrl
  import nco_mod_pkg::*;
#(
  parameter int ACC_W  = 48,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_i,
  input  mode_e             mode_i,
  input  logic              key_q_i,
  input  logic [ACC_W-1:0]  ftw_a_i,
  input  logic [ACC_W-1:0]  ftw_b_i,
  input  logic [ACC_W-1:0]  step_i,
  input  logic [RATE_W-1:0] ival_i,
  input  logic [ACC_W-1:0]  ld_ftw_a_i,
  input  logic [RATE_W-1:0] ld_ival_i,
  output logic [ACC_W-1:0]  freq_o
);

  logic [ACC_W-1:0]  ramp_f;
  logic [RATE_W-1:0] ival_cnt;
  logic [ACC_W-1:0]  tgt, gap_up, gap_dn, rfsk_next, chirp_next;
  logic              tick_due;

  assign tick_due = (ival_cnt == '0);

  always_comb begin
    tgt        = key_q_i ? ftw_b_i : ftw_a_i;
    gap_up     = tgt - ramp_f;
    gap_dn     = ramp_f - tgt;
    chirp_next = ramp_f + step_i;
    if (ramp_f < tgt)
      rfsk_next = (gap_up <= step_i) ? tgt : ramp_f + step_i;
    else if (ramp_f > tgt)
      rfsk_next = (gap_dn <= step_i) ? tgt : ramp_f - step_i;
    else
      rfsk_next = ramp_f;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ramp_f   <= '0;
      ival_cnt <= '0;
    end else if (upd_i) begin
      ramp_f   <= ld_ftw_a_i;
      ival_cnt <= ld_ival_i;
    end else begin
      case (mode_i)
        MODE_RFSK: begin
          if (tick_due) begin
            ramp_f   <= rfsk_next;
            ival_cnt <= ival_i;
          end else begin
            ival_cnt <= ival_cnt - 1'b1;
          end
        end
        MODE_CHIRP: begin
          if (!key_q_i) begin
            if (tick_due) begin
              ramp_f   <= chirp_next;
              ival_cnt <= ival_i;
            end else begin
              ival_cnt <= ival_cnt - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (mode_i)
      MODE_RFSK, MODE_CHIRP: freq_o = ramp_f;
      MODE_FSK:              freq_o = key_q_i ? ftw_b_i : ftw_a_i;
      default:               freq_o = ftw_a_i;
    endcase
  end

  AST_RFSK_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_RFSK && !upd_i && ramp_f == tgt) |=> ramp_f == $past(ramp_f))
    else $error("ramp left its target"); // R6

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ival_cnt <= ival_i)
    else $error("interval counter above its reload"); // R6

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_CHIRP && key_q_i && !upd_i) |=> ($stable(ramp_f) && $stable(ival_cnt)))
    else $error("chirp moved during hold"); // R8

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 48,
  parameter int PH_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freq_i,
  input  logic [PH_W-1:0]  offset_i,
  output logic [PH_W-1:0]  phase_o
);

  logic [ACC_W-1:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc + freq_i;
  end

  assign phase_o = acc[ACC_W-1 -: PH_W] + offset_i;

  AST_ZERO_FREQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && freq_i == '0) |=> $stable(acc))
    else $error("accumulator drifted at zero frequency"); // R2

endmodule

// File: rtl/nco_mod_ctrl.sv
module nco_mod_ctrl
  import nco_mod_pkg::*;
#(
  parameter int ACC_W  = 48,
  parameter int PH_W   = 14,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [ACC_W-1:0]  wr_data,
  input  logic              upd_strobe,
  input  logic              key_pin,
  output logic [PH_W-1:0]   phase_word,
  output logic [ACC_W-1:0]  freq_word
);

  logic [ACC_W-1:0]  ftw_a, ftw_b, step, ld_ftw_a;
  logic [PH_W-1:0]   ph_a, ph_b, offset;
  logic [RATE_W-1:0] ival, ld_ival;
  mode_e             mode;
  logic              key_q;

  always_ff @(posedge clk) begin
    if (!rst_n) key_q <= 1'b0;
    else        key_q <= key_pin;
  end

  nco_regbank #(.ACC_W(ACC_W), .PH_W(PH_W), .RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .upd_strobe(upd_strobe),
    .act_ftw_a(ftw_a), .act_ftw_b(ftw_b), .act_ph_a(ph_a), .act_ph_b(ph_b),
    .act_step(step), .act_ival(ival), .act_mode(mode),
    .sh_ftw_a_o(ld_ftw_a), .sh_ival_o(ld_ival)
  );

  nco_freq_ctrl #(.ACC_W(ACC_W), .RATE_W(RATE_W)) u_freq (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_strobe), .mode_i(mode),
    .key_q_i(key_q), .ftw_a_i(ftw_a), .ftw_b_i(ftw_b), .step_i(step),
    .ival_i(ival), .ld_ftw_a_i(ld_ftw_a), .ld_ival_i(ld_ival),
    .freq_o(freq_word)
  );

  assign offset = (mode == MODE_BPSK && key_q) ? ph_b : ph_a;

  nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .freq_i(freq_word), .offset_i(offset),
    .phase_o(phase_word)
  );

  AST_TONE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TONE && !upd_strobe) |=> $stable(freq_word))
    else $error("single tone frequency moved"); // R4

  AST_BPSK_FREQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_BPSK) |-> freq_word == ftw_a)
    else $error("BPSK frequency not word A"); // R9

endmodule

// File: tb/nco_mod_ctrl_tb.sv
`timescale 1ns/1ps
module nco_mod_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [47:0] wr_data;
  logic        upd_strobe;
  logic        key_pin;
  logic [13:0] phase_word;
  logic [47:0] freq_word;

  always #5 clk = ~clk;

  nco_mod_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .upd_strobe(upd_strobe), .key_pin(key_pin),
    .phase_word(phase_word), .freq_word(freq_word)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  string force_tag = "";

  // behavioural model state
  logic [47:0] s_reg [0:6];
  logic [47:0] a_reg [0:6];
  logic [47:0] m_acc, m_ramp;
  int          m_cnt;
  bit          m_key;

  function automatic logic [47:0] m_freq();
    case (a_reg[6][2:0])
      3'd1: return m_key ? a_reg[1] : a_reg[0];
      3'd2, 3'd3: return m_ramp;
      default: return a_reg[0];
    endcase
  endfunction

  function automatic logic [13:0] m_phase();
    logic [47:0] off;
    off = (a_reg[6][2:0] == 3'd4 && m_key) ? a_reg[3] : a_reg[2];
    return 14'((m_acc / 48'h4_0000_0000) + off);
  endfunction

  function automatic string mode_tag();
    case (a_reg[6][2:0])
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return m_key ? "R8" : "R7";
      3'd4: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [47:0] act, logic [47:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 7; i++) begin s_reg[i] = '0; a_reg[i] = '0; end
    m_acc = '0; m_ramp = '0; m_cnt = 0; m_key = 0;
  endtask

  task automatic model_step();
    logic [47:0] f, tgt, stp;
    f = m_freq();
    m_acc = m_acc + f;
    if (upd_strobe) begin
      m_ramp = s_reg[0];
      m_cnt  = int'(s_reg[5][15:0]);
    end else begin
      stp = a_reg[4];
      if (a_reg[6][2:0] == 3'd2) begin
        if (m_cnt == 0) begin
          tgt = m_key ? a_reg[1] : a_reg[0];
          if (m_ramp < tgt)      m_ramp = (tgt - m_ramp <= stp) ? tgt : m_ramp + stp;
          else if (m_ramp > tgt) m_ramp = (m_ramp - tgt <= stp) ? tgt : m_ramp - stp;
          m_cnt = int'(a_reg[5][15:0]);
        end else m_cnt--;
      end else if (a_reg[6][2:0] == 3'd3 && !m_key) begin
        if (m_cnt == 0) begin
          m_ramp = m_ramp + stp;
          m_cnt  = int'(a_reg[5][15:0]);
        end else m_cnt--;
      end
    end
    if (upd_strobe) for (int i = 0; i < 7; i++) a_reg[i] = s_reg[i];
    if (wr_en && wr_addr < 3'd7) begin
      case (wr_addr)
        3'd2, 3'd3: s_reg[wr_addr] = {34'd0, wr_data[13:0]};
        3'd5:       s_reg[wr_addr] = {32'd0, wr_data[15:0]};
        3'd6:       s_reg[wr_addr] = {45'd0, wr_data[2:0]};
        default:    s_reg[wr_addr] = wr_data;
      endcase
    end
    m_key = key_pin;
  endtask

  task automatic tick();
    @(posedge clk);
    if (!rst_n) model_reset();
    else        model_step();
    #2;
    if (rst_n) begin
      check(freq_word == m_freq(), (force_tag != "") ? force_tag : mode_tag(),
            freq_word, m_freq());
      check(phase_word == m_phase(), (force_tag != "") ? force_tag : "R2",
            {34'd0, phase_word}, {34'd0, m_phase()});
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [47:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic upd();
    upd_strobe = 1;
    tick();
    upd_strobe = 0;
  endtask

  task automatic run(int n, int key_period);
    for (int i = 0; i < n; i++) begin
      if (key_period > 0 && (i % key_period) == 0) key_pin = ~key_pin;
      tick();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0; upd_strobe = 0; key_pin = 0;
    model_reset();
    repeat (3) tick();
    #1;
    check(phase_word == 14'd0, "R1", {34'd0, phase_word}, 48'd0);
    check(freq_word == 48'd0, "R1", freq_word, 48'd0);
    @(negedge clk);
    rst_n = 1;
    tick();
    check(freq_word == 48'd0 && phase_word == 14'd0, "R1", freq_word, 48'd0);

    // shadow writes without strobe leave outputs untouched
    force_tag = "R3";
    wr(3'd0, 48'h0123_4567_89AB);
    wr(3'd2, 48'h0000_0000_1234);
    run(5, 0);
    check(freq_word == 48'd0, "R3", freq_word, 48'd0);
    force_tag = "";
    upd();

    // single tone, pin toggling ignored
    run(20, 3);

    // FSK
    wr(3'd1, 48'h0F00_0000_0000);
    wr(3'd6, 48'd1);
    upd();
    run(25, 4);
    run(15, 7);

    // ramped FSK: step does not divide the distance
    key_pin = 0;
    wr(3'd0, 48'h0000_1000_0000);
    wr(3'd1, 48'h0000_1000_0A00);
    wr(3'd4, 48'h0000_0000_0300);
    wr(3'd5, 48'd3);
    wr(3'd6, 48'd2);
    upd();
    run(20, 0);
    key_pin = 1;
    run(40, 0);
    key_pin = 0;
    run(40, 0);

    // chirp with negative step and holds
    wr(3'd4, 48'hFFFF_FFFF_F000);
    wr(3'd5, 48'd2);
    wr(3'd6, 48'd3);
    upd();
    run(15, 0);
    key_pin = 1; run(6, 0);
    key_pin = 0; run(4, 0);
    key_pin = 1; run(1, 0);
    key_pin = 0; run(15, 0);

    // write on the same edge as the strobe stays in shadow
    force_tag = "R3";
    wr_en = 1; wr_addr = 3'd0; wr_data = 48'h0000_0000_0777;
    upd_strobe = 1;
    tick();
    wr_en = 0; upd_strobe = 0;
    run(3, 0);
    force_tag = "";

    // BPSK
    wr(3'd3, 48'h0000_0000_2000);
    wr(3'd6, 48'd4);
    upd();
    run(30, 3);
    run(10, 5);

    // unused codes act as single tone
    for (int c = 5; c < 8; c++) begin
      wr(3'd6, 48'(c));
      upd();
      run(12, 2);
    end

    finish_run();
  end

endmodule